// File: doc/BRIEF.md
# Sticky Second-Level Interrupt Aggregator

This block gathers a set of second-level interrupt request lines into one 32-bit status register and drives a single level-type interrupt request toward a microcontroller's first-level interrupt controller. Each implemented status bit latches whenever its request line is high. It stays latched until software writes a one to that bit position through a simple register bus. The status register has no mask. A source that must be silenced is disabled at the source itself.

Every one written to an implemented bit also produces a one-cycle clear pulse on a per-bit output. A downstream source can use this pulse to react to being acknowledged. The interrupt-redirection host-request source at bit 6 relies on it. Because a request line that is still high sets its bit again on the same edge, a clear only takes effect once the source has dropped. The status register sits at bus offset 0x688. Bits 0 to 9 and bit 13 are implemented, and the other positions are reserved.

Top module: `subirq_aggregator`

## Requirements
- R1: While reset is held, and in the cycle after it, the status register reads 0, `irq_out` is 0 and `clr_pulse` is 0.
- R2: An implemented status bit becomes 1 at the first rising edge at which its request line is sampled high. The bit is readable right after that edge.
- R3: A set status bit stays 1 after its request line returns to 0. It clears only on a bus write to offset 0x688 with a 1 in that position. Writing 0 to a bit leaves it unchanged.
- R4: If a request line is high at the same edge at which software writes 1 to its bit, the bit stays 1.
- R5: `irq_out` is registered. After each rising edge it equals whether the status register was nonzero before that edge.
- R6: There is no mask. Every implemented bit (0 to 9 and 13) on its own raises `irq_out` when set.
- R7: Bit positions 10 to 12 and 14 to 31 read as 0. Request lines 10 to 12 and writes to those positions are ignored.
- R8: For a bus write to offset 0x688, `clr_pulse[i]` is 1 for exactly the cycle after the write edge, for each implemented bit i written with 1. This holds whether or not the bit was set. Otherwise it is 0.
- R9: `bus_rdata` shows the current status when `bus_addr` is 0x688 and 0 otherwise. Reading has no side effect.
- R10: Writes to any offset other than 0x688 change neither the status register nor `clr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 14 | Second-level request lines, level sensitive |
| bus_addr | input | 12 | Register bus byte offset |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data, write-one-to-clear |
| bus_rdata | output | 32 | Combinational read data |
| irq_out | output | 1 | Merged level interrupt, registered |
| clr_pulse | output | 14 | One-cycle clear notification per bit |

## Verification
A request sampled at a rising edge appears in `bus_rdata` right after that edge. `irq_out` follows one edge later. A write to 0x688 clears the status bits and raises `clr_pulse` at the same edge, while `irq_out` falls one edge after the clear. The bench drives inputs at the falling edge and advances an arithmetic model of status, interrupt and pulse at each rising edge. It then compares every output with that model at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/sia_pkg.sv
// Package: shared widths and types for the sticky interrupt aggregator.
// Assumes a 32-bit register bus with byte offsets of ADDR_W bits.
package sia_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned SRC_W  = 14;

    typedef logic [REG_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/sia_busif.sv
// Module: register bus front end.
// Decodes write-one-to-clear requests for the status offset, registers a
// one-cycle clear pulse per implemented bit, and drives combinational read data.
// Assumes a single-cycle write strobe and side-effect-free reads.
module sia_busif
    import sia_pkg::*;
#(
    parameter addr_t       STATUS_OFS = 12'h688,
    parameter word_t       IMPL_MASK  = 32'h0000_23FF,
    parameter int unsigned PULSE_W    = SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  addr_t              addr,
    input  logic               wr_en,
    input  word_t              wdata,
    input  word_t              status,
    output word_t              clr_req,
    output word_t              rd_data,
    output logic [PULSE_W-1:0] clr_pulse
);
    logic wr_hit;
    logic rd_hit;
    logic [PULSE_W-1:0] pulse_q;

    // Address decode for the single status register.
    always_comb begin
        wr_hit = wr_en && (addr == STATUS_OFS);
        rd_hit = (addr == STATUS_OFS);
    end

    // Clear request: ones written to implemented bit positions only.
    always_comb begin
        clr_req = wr_hit ? (wdata & IMPL_MASK) : '0;
    end

    // Read mux: status at the decoded offset, zero elsewhere.
    always_comb begin
        rd_data = rd_hit ? status : '0;
    end

    // Register the clear notification so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= clr_req[PULSE_W-1:0];
    end

    assign clr_pulse = pulse_q;
endmodule

// File: rtl/sia_sticky_bank.sv
// Module: bank of sticky status bits.
// Each implemented bit sets on a high request level and clears on a
// write-one request. Set wins over clear. Unimplemented positions are tied
// to zero. Assumes clr_vec is already masked to implemented positions.
module sia_sticky_bank
    import sia_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0000_23FF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_vec,
    input  word_t clr_vec,
    output word_t status
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic bit_q;
            // Sticky bit: reset to 0, set has priority, else write-one clears.
            always_ff @(posedge clk) begin
                if (!rst_n)          bit_q <= 1'b0;
                else if (set_vec[i]) bit_q <= 1'b1;
                else if (clr_vec[i]) bit_q <= 1'b0;
            end
            assign status[i] = bit_q;
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = set_vec[i] | clr_vec[i];
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sia_irq_merge.sv
// Module: merges the status vector into one registered level interrupt.
// Assumes the status vector already excludes reserved positions.
module sia_irq_merge
    import sia_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t status,
    output logic  irq
);
    logic irq_q;

    // Register the OR of all status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status;
    end

    assign irq = irq_q;
endmodule

// File: rtl/subirq_aggregator.sv
// Module: top of the sticky second-level interrupt aggregator.
// Latches request lines into a write-one-to-clear status register with no
// mask, raises a registered level interrupt while any bit is set, and emits
// per-bit clear pulses. Assumes request lines are synchronous to clk.
module subirq_aggregator
    import sia_pkg::*;
#(
    parameter addr_t STATUS_OFS = 12'h688,
    parameter word_t IMPL_MASK  = 32'h0000_23FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out,
    output logic [SRC_W-1:0]  clr_pulse
);
    word_t set_w;
    word_t clr_w;
    word_t status_w;

    // Widen request lines to register width.
    assign set_w = REG_W'(src_req);

    sia_busif #(
        .STATUS_OFS (STATUS_OFS),
        .IMPL_MASK  (IMPL_MASK),
        .PULSE_W    (SRC_W)
    ) u_busif (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr_en     (bus_wr_en),
        .wdata     (bus_wdata),
        .status    (status_w),
        .clr_req   (clr_w),
        .rd_data   (bus_rdata),
        .clr_pulse (clr_pulse)
    );

    sia_sticky_bank #(
        .IMPL_MASK (IMPL_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_w),
        .clr_vec (clr_w),
        .status  (status_w)
    );

    sia_irq_merge u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_w),
        .irq    (irq_out)
    );
endmodule

// File: rtl/sia_checker.sv
// Module: property checker for subirq_aggregator, attached by bind.
// Observes ports and the internal status vector between bank and merge logic.
module sia_checker
    import sia_pkg::*;
#(
    parameter addr_t STATUS_OFS = 12'h688,
    parameter word_t IMPL_MASK  = 32'h0000_23FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              irq_out,
    input logic [SRC_W-1:0]  clr_pulse,
    input logic [REG_W-1:0]  status_w
);
    word_t req_m;
    word_t wr1_m;

    // Expected set and clear vectors seen from the ports.
    always_comb begin
        req_m = REG_W'(src_req) & IMPL_MASK;
        wr1_m = (bus_wr_en && bus_addr == STATUS_OFS) ? (bus_wdata & IMPL_MASK) : '0;
    end

    assert_set_on_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_w & $past(req_m)) == $past(req_m)));

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_w) & ~$past(wr1_m) & ~status_w) == '0));

    assert_clear_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(wr1_m) & ~$past(req_m) & status_w) == '0));

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == ($past(status_w) != '0)));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & ~IMPL_MASK) == '0) && ((bus_rdata & ~IMPL_MASK) == '0));

    assert_clear_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clr_pulse == $past(wr1_m[SRC_W-1:0])));

    assert_read_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STATUS_OFS) |-> (bus_rdata == '0));
endmodule

bind subirq_aggregator sia_checker #(
    .STATUS_OFS (STATUS_OFS),
    .IMPL_MASK  (IMPL_MASK)
) u_sia_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .clr_pulse (clr_pulse),
    .status_w  (status_w)
);

// File: tb/test_subirq_aggregator.sv
// Bench: drives at the falling edge, advances an arithmetic model at each
// rising edge, compares outputs at the following falling edge.
module test_subirq_aggregator;
    localparam logic [11:0] OFS  = 12'h688;
    localparam logic [31:0] MASK = 32'h0000_23FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_req = '0;
    logic [11:0] bus_addr = OFS;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [13:0] clr_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_st = '0;
    logic        m_irq = 1'b0;
    logic [13:0] m_clr = '0;

    always #5 clk = ~clk;

    subirq_aggregator i_subirq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .clr_pulse (clr_pulse)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(bus_rdata, (bus_addr == OFS) ? m_st : 32'h0, tag, "rdata");
        chk({31'h0, irq_out}, {31'h0, m_irq}, tag, "irq_out");
        chk({18'h0, clr_pulse}, {18'h0, m_clr}, tag, "clr_pulse");
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge.
    task automatic step(input logic [13:0] s, input logic we, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] clr;
        src_req = s; bus_wr_en = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        clr   = (we && a == OFS) ? (d & MASK) : 32'h0;
        m_irq = (m_st != 32'h0);
        m_st  = (m_st & ~clr) | ({18'h0, s} & MASK);
        m_clr = clr[13:0];
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        src_req = 14'h3FFF; bus_wr_en = 1'b1; bus_wdata = '1;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        src_req = '0; bus_wr_en = 1'b0; bus_wdata = '0;
        rst_n = 1'b1;
        step('0, 1'b0, OFS, '0, "R1 after reset");

        // R2 R6 R7: single-source sweep over every request line.
        for (int b = 0; b < 14; b++) begin
            step(14'(1 << b), 1'b0, OFS, '0, "R2 set");
            step('0, 1'b0, OFS, '0, "R3 sticky R6 irq");
            step('0, 1'b0, OFS, '0, "R5 irq level");
            step('0, 1'b1, OFS, 32'(1) << b, "R8 clear pulse");
            step('0, 1'b0, OFS, '0, "R5 irq drop");
        end

        // R3: writing zero leaves every bit set.
        step(14'h3FFF, 1'b0, OFS, '0, "R2 all");
        step('0, 1'b1, OFS, 32'h0, "R3 write zero");
        step('0, 1'b1, OFS, 32'hFFFF_DC00, "R3 R7 reserved write");
        step('0, 1'b0, OFS, '0, "R3 hold");

        // R10: writes at other offsets are ignored.
        step('0, 1'b1, 12'h68C, '1, "R10 other offset");
        step('0, 1'b1, 12'h000, '1, "R10 offset zero");
        // R9: reads elsewhere return zero, reading has no side effect.
        step('0, 1'b0, 12'h684, '0, "R9 other read");
        step('0, 1'b0, OFS, '0, "R9 reread");
        step('0, 1'b0, OFS, '0, "R9 reread twice");

        // R4: request held high during write keeps the bit.
        step(14'h0040, 1'b1, OFS, 32'h0000_0040, "R4 set wins");
        step(14'h0040, 1'b1, OFS, '1, "R4 set wins all");
        step('0, 1'b1, OFS, 32'h0000_0040, "R4 clear after drop");
        step('0, 1'b1, OFS, '1, "R8 clear all");
        step('0, 1'b0, OFS, '0, "R5 idle");

        // R8: pulses even when the status is already zero.
        step('0, 1'b1, OFS, 32'h0000_2155, "R8 pulse idle");
        step('0, 1'b1, OFS, 32'h0000_1C00, "R7 R8 reserved pulse");

        // Multi-bit patterns with partial clears.
        for (int p = 0; p < 16; p++) begin
            step(14'((p * 14'h0A53) ^ (p << 3)), 1'b0, OFS, '0, "R2 pattern");
            step('0, 1'b1, OFS, 32'(p * 32'h0000_0137), "R3 partial clear");
            step('0, 1'b0, OFS, '0, "R5 pattern irq");
        end
        step('0, 1'b1, OFS, '1, "R3 final clear");
        step('0, 1'b0, OFS, '0, "R5 final idle");

        // R1: reset in mid-operation.
        step(14'h23FF, 1'b0, OFS, '0, "R2 before reset");
        rst_n = 1'b0;
        @(posedge clk);
        m_st = '0; m_irq = 1'b0; m_clr = '0;
        @(negedge clk);
        check_all("R1 mid reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule